// File: doc/BRIEF.md
# Sequential Outer Bank Register Combiner

This block sits next to an inner bank controller on a cartridge bus. It holds four outer bank bytes that all share one CPU register address. A write pointer picks which byte each write loads. Four qualified writes fill bytes 0 to 3 in turn, and the fifth write starts again at byte 0.

The block merges the inner 8 KiB PRG bank number and the inner 1 KiB CHR bank number with the outer values under two masks. It outputs the final PRG and CHR bank numbers. It also reorders the bits of CHR read data and raises a select for the CPU work-RAM window.

The write pointer is a state machine with four states, `SLOT0`, `SLOT1`, `SLOT2` and `SLOT3`. It has two kinds of transition:
- **ADVANCE**: on a write that hits the register address, it steps from one slot to the next (`SLOT0`→`SLOT1`→`SLOT2`→`SLOT3`).
- **WRAP**: a hit in `SLOT3` returns it to `SLOT0`.

Any other cycle is **HOLD**, and the state does not change. Reset forces `SLOT0`.

Top module: `obank_combiner`

## Requirements
- R1: After reset, bytes 0, 1 and 3 hold 0x00, byte 2 holds 0x0F and the pointer is at slot 0. The PRG bank then equals the zero-extended inner PRG bank, and the CHR bank equals 0.
- R2: A write hits the register when cpu_wr is 1 and (cpu_addr AND 0xF008) equals 0x5000. Successive hits load byte 0, byte 1, byte 2 and byte 3, and the fifth hit loads byte 0 again.
- R3: A write whose address fails the decode (for example 0x5008 or 0x4000) changes no byte and does not move the pointer.
- R4: With cpu_wr at 0, nothing is loaded and the pointer holds, whatever the address.
- R5: PRG bank bits 0–5 are (inner AND NOT m) OR (byte1 AND m), where m is bits 5:0 of byte 3.
- R6: PRG bank bits 6–7 are byte 1 bits 7:6, and PRG bank bits 8–9 are byte 3 bits 7:6.
- R7: The CHR mask is n leading ones in an 8-bit field, where n is bits 3:0 of byte 2. Any n of 8 or more gives 0xFF. CHR bank bits 0–7 are (inner AND NOT mask) OR (byte0 AND mask).
- R8: CHR bank bits 8–11 are byte 2 bits 7:4, and CHR bank bits 12–13 are byte 3 bits 7:6.
- R9: chr_data_o is a bit permutation of chr_data_i, with output bit positions taking input bits as follows: 7←7, 6←0, 5←6, 4←1, 3←5, 2←2, 1←4, 0←3.
- R10: wram_sel is 1 exactly when cpu_addr lies in 0x6000–0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Qualified write strobe, one cycle per write |
| inner_prg | input | 6 | Inner 8 KiB PRG bank number |
| inner_chr | input | 8 | Inner 1 KiB CHR bank number |
| chr_data_i | input | 8 | Stored CHR read data |
| prg_bank | output | 10 | Final PRG bank number |
| chr_bank | output | 14 | Final CHR bank number |
| chr_data_o | output | 8 | Reordered CHR read data |
| wram_sel | output | 1 | Work-RAM window select |

## Verification
The bench builds the block with its default decode address 0x5000, decode mask 0xF008 and reset value 0x0F for byte 2. These defaults make decode misses on address bit 3 and on the high nibble observable, and they put the full-mask CHR state within reach directly from reset. Directed writes then set the CHR count to exactly 8 and to 0, which brings the saturating and empty mask boundaries into play. A mid-run reset shows the pointer returning to slot 0.

// File: rtl/obank_pkg.sv
package obank_pkg;
    localparam int BYTE_W     = 8;
    localparam int NREG       = 4;
    localparam int PRG_MASK_W = 6;
    localparam int PRG_W      = 10;
    localparam int CHR_W      = 14;

    typedef enum logic [1:0] {
        SLOT0 = 2'd0,
        SLOT1 = 2'd1,
        SLOT2 = 2'd2,
        SLOT3 = 2'd3
    } slot_e;
endpackage

// File: rtl/obank_regfile.sv
module obank_regfile
    import obank_pkg::*;
#(
    parameter logic [BYTE_W-1:0] BYTE2_INIT = 8'h0F
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hit,
    input  logic [BYTE_W-1:0]             wdata,
    output logic [NREG-1:0][BYTE_W-1:0]   regs_q
);
    slot_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT0;
        else        state <= state_nx;
    end

    // transitions: ADVANCE, WRAP, HOLD
    always_comb begin
        state_nx = state;
        if (hit) begin
            unique case (state)
                SLOT0: state_nx = SLOT1;
                SLOT1: state_nx = SLOT2;
                SLOT2: state_nx = SLOT3;
                SLOT3: state_nx = SLOT0;
            endcase
        end
    end

    // output bytes loaded by slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q[0] <= '0;
            regs_q[1] <= '0;
            regs_q[2] <= BYTE2_INIT;
            regs_q[3] <= '0;
        end else if (hit) begin
            unique case (state)
                SLOT0: regs_q[0] <= wdata;
                SLOT1: regs_q[1] <= wdata;
                SLOT2: regs_q[2] <= wdata;
                SLOT3: regs_q[3] <= wdata;
            endcase
        end
    end

    // R2: pointer steps by one on each hit
    a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        hit && state != SLOT3 |=> state == slot_e'(2'($past(state) + 2'd1)));
    // R2: fifth hit wraps to slot 0
    a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        hit && state == SLOT3 |=> state == SLOT0);
    // R3, R4: no hit, nothing moves
    a_r3_no_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(state) && $stable(regs_q));
endmodule

// File: rtl/obank_merge.sv
module obank_merge
    import obank_pkg::*;
(
    input  logic [NREG-1:0][BYTE_W-1:0] regs,
    input  logic [PRG_MASK_W-1:0]       inner_prg,
    input  logic [BYTE_W-1:0]           inner_chr,
    output logic [PRG_W-1:0]            prg_bank,
    output logic [CHR_W-1:0]            chr_bank
);
    logic [3:0]            chr_cnt;
    logic [BYTE_W-1:0]     chr_mask;
    logic [PRG_MASK_W-1:0] prg_mask;

    assign chr_cnt  = regs[2][3:0];
    assign prg_mask = regs[3][PRG_MASK_W-1:0];

    // leading-ones mask: bit (7-k) is set when count exceeds k
    for (genvar k = 0; k < BYTE_W; k++) begin : g_cmask
        assign chr_mask[BYTE_W-1-k] = (chr_cnt > 4'(k));
    end

    assign prg_bank = {regs[3][7:6], regs[1][7:6],
                       (inner_prg & ~prg_mask) | (regs[1][PRG_MASK_W-1:0] & prg_mask)};
    assign chr_bank = {regs[3][7:6], regs[2][7:4],
                       (inner_chr & ~chr_mask) | (regs[0] & chr_mask)};
endmodule

// File: rtl/obank_chr_unscramble.sv
module obank_chr_unscramble
    import obank_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    function automatic int src_of(input int dst);
        case (dst)
            7: return 7;  6: return 0;  5: return 6;  4: return 1;
            3: return 5;  2: return 2;  1: return 4;  default: return 3;
        endcase
    endfunction

    for (genvar i = 0; i < BYTE_W; i++) begin : g_perm
        assign dout[i] = din[src_of(i)];
    end
endmodule

// File: rtl/obank_combiner.sv
module obank_combiner
    import obank_pkg::*;
#(
    parameter logic [15:0]       REG_ADDR   = 16'h5000,
    parameter logic [15:0]       DEC_MASK   = 16'hF008,
    parameter logic [15:0]       WRAM_BASE  = 16'h6000,
    parameter logic [15:0]       WRAM_MASK  = 16'hE000,
    parameter logic [BYTE_W-1:0] BYTE2_INIT = 8'h0F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic [BYTE_W-1:0]     cpu_wdata,
    input  logic                  cpu_wr,
    input  logic [PRG_MASK_W-1:0] inner_prg,
    input  logic [BYTE_W-1:0]     inner_chr,
    input  logic [BYTE_W-1:0]     chr_data_i,
    output logic [PRG_W-1:0]      prg_bank,
    output logic [CHR_W-1:0]      chr_bank,
    output logic [BYTE_W-1:0]     chr_data_o,
    output logic                  wram_sel
);
    logic                        hit;
    logic [NREG-1:0][BYTE_W-1:0] regs;

    assign hit      = cpu_wr && ((cpu_addr & DEC_MASK) == REG_ADDR);
    assign wram_sel = (cpu_addr & WRAM_MASK) == WRAM_BASE;

    obank_regfile #(.BYTE2_INIT(BYTE2_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wdata(cpu_wdata), .regs_q(regs)
    );

    obank_merge u_merge (
        .regs(regs), .inner_prg(inner_prg), .inner_chr(inner_chr),
        .prg_bank(prg_bank), .chr_bank(chr_bank)
    );

    obank_chr_unscramble u_unscr (.din(chr_data_i), .dout(chr_data_o));

    // R5: bits outside the PRG mask follow the inner bank
    a_r5_prg_inner_keep: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((prg_bank[PRG_MASK_W-1:0] ^ inner_prg) & ~regs[3][PRG_MASK_W-1:0]) == '0);
    // R7: saturated count selects the outer byte entirely
    a_r7_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        regs[2][3] |-> chr_bank[7:0] == regs[0]);
    // R7: zero count passes the inner byte
    a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        regs[2][3:0] == 4'd0 |-> chr_bank[7:0] == inner_chr);
    // R10: window select
    a_r10_wram: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15:13] == 3'b011 |-> wram_sel);
    // R9: top bit is unmoved
    a_r9_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> chr_data_o[7] == chr_data_i[7]);
endmodule

// File: tb/obank_combiner_bench.sv
module obank_combiner_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 0;
    logic [5:0]  inner_prg = '0;
    logic [7:0]  inner_chr = '0;
    logic [7:0]  chr_data_i = '0;
    logic [9:0]  prg_bank;
    logic [13:0] chr_bank;
    logic [7:0]  chr_data_o;
    logic        wram_sel;

    int nchk = 0, nfail = 0;
    logic [7:0] m_reg [4];
    int m_ptr;

    always #2 clk = ~clk;

    obank_combiner u_obank_combiner (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .inner_prg(inner_prg), .inner_chr(inner_chr),
        .chr_data_i(chr_data_i), .prg_bank(prg_bank), .chr_bank(chr_bank),
        .chr_data_o(chr_data_o), .wram_sel(wram_sel)
    );

    // vector: wr, addr, wdata, inner_prg, inner_chr, chr_data
    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [5:0]  iprg;
        logic [7:0]  ichr;
        logic [7:0]  cdat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h5000, 8'hA5, 6'h15, 8'h5A, 8'h01},  // R2 byte0
        '{1'b1, 16'h5000, 8'h3C, 6'h2A, 8'hC3, 8'h02},  // R2 byte1
        '{1'b1, 16'h5008, 8'hFF, 6'h3F, 8'hFF, 8'h04},  // R3 miss bit3
        '{1'b1, 16'h5000, 8'h24, 6'h00, 8'h0F, 8'h08},  // R2 byte2 cnt4
        '{1'b1, 16'h4000, 8'h77, 6'h11, 8'h88, 8'h10},  // R3 miss nibble
        '{1'b1, 16'h5000, 8'hC7, 6'h38, 8'h33, 8'h20},  // R2 byte3
        '{1'b1, 16'h5FF7, 8'h11, 6'h07, 8'hAA, 8'h40},  // R2 wrap, alias
        '{1'b0, 16'h5000, 8'h99, 6'h1C, 8'h55, 8'h80},  // R4 strobe low
        '{1'b0, 16'h6000, 8'h00, 6'h3A, 8'h01, 8'hFF},  // R10 low edge
        '{1'b0, 16'h7FFF, 8'h00, 6'h05, 8'hF0, 8'h96},  // R10 high edge
        '{1'b0, 16'h8000, 8'h00, 6'h2B, 8'h7E, 8'h69},  // R10 above
        '{1'b0, 16'h5FFF, 8'h00, 6'h01, 8'h81, 8'h3C},  // R10 below
        '{1'b1, 16'h5000, 8'hF1, 6'h3E, 8'h18, 8'hC5},  // R2 byte1
        '{1'b1, 16'h5000, 8'h5B, 6'h12, 8'hE7, 8'h5A}   // R7 cnt 11
    };

    function automatic logic [7:0] exp_perm(input logic [7:0] d);
        return {d[7], d[0], d[6], d[1], d[5], d[2], d[4], d[3]};
    endfunction

    function automatic logic [7:0] exp_cmask(input logic [3:0] n);
        return (n >= 4'd8) ? 8'hFF : 8'(~(8'hFF >> n));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_reg[0] = 8'h00; m_reg[1] = 8'h00; m_reg[2] = 8'h0F; m_reg[3] = 8'h00;
        m_ptr = 0;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] cm;
        logic [5:0] pm;
        cm = exp_cmask(m_reg[2][3:0]);
        pm = m_reg[3][5:0];
        chk({tag, " R5/R6 prg"}, 32'(prg_bank),
            32'({m_reg[3][7:6], m_reg[1][7:6], (inner_prg & ~pm) | (m_reg[1][5:0] & pm)}));
        chk({tag, " R7/R8 chr"}, 32'(chr_bank),
            32'({m_reg[3][7:6], m_reg[2][7:4], (inner_chr & ~cm) | (m_reg[0] & cm)}));
        chk({tag, " R9 data"}, 32'(chr_data_o), 32'(exp_perm(chr_data_i)));
        chk({tag, " R10 wram"}, 32'(wram_sel),
            32'(cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF));
    endtask

    // drive at negedge, let one posedge pass, check at next negedge
    task automatic apply(input vec_t v);
        cpu_wr = v.wr; cpu_addr = v.addr; cpu_wdata = v.wdata;
        inner_prg = v.iprg; inner_chr = v.ichr; chr_data_i = v.cdat;
        @(negedge clk);
        if (v.wr && ((v.addr & 16'hF008) == 16'h5000)) begin
            m_reg[m_ptr] = v.wdata;
            m_ptr = (m_ptr + 1) % 4;
        end
        cpu_wr = 0;
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        model_reset();
        inner_prg = 6'h2D; inner_chr = 8'h6B;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 prg", 32'(prg_bank), 32'({4'b0, 6'h2D}));
        chk("R1 chr", 32'(chr_bank), 32'h0);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 post");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check_all($sformatf("vec%0d", i));
        end

        // R7: count 8 exactly, then 0 (advance pointer to slot 2 first)
        while (m_ptr != 2) apply('{1'b1, 16'h5000, 8'h6E, 6'h09, 8'h42, 8'h00});
        apply('{1'b1, 16'h5000, 8'h98, 6'h33, 8'h3D, 8'h17});
        check_all("R7 cnt8");
        while (m_ptr != 2) apply('{1'b1, 16'h5000, 8'hD2, 6'h27, 8'h9C, 8'h00});
        apply('{1'b1, 16'h5000, 8'h50, 6'h1B, 8'hB4, 8'hE8});
        check_all("R7 cnt0");
        chk("R7 cnt0 inner low", 32'(chr_bank[7:0]), 32'(8'hB4));

        // R4: strobe low for several cycles, nothing changes
        apply('{1'b0, 16'h5000, 8'hFF, 6'h1B, 8'hB4, 8'h00});
        apply('{1'b0, 16'h5000, 8'hFF, 6'h1B, 8'hB4, 8'h00});
        check_all("R4 held");

        // R1: mid-run reset returns pointer to slot 0
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        check_all("R1 rerun");
        apply('{1'b1, 16'h5000, 8'h42, 6'h00, 8'h00, 8'h00});
        chk("R1 ptr slot0", 32'(chr_bank), 32'h42);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule